// File: doc/BRIEF.md
# Burst-Locked Subcarrier Phase Loop

This block rebuilds a local colour subcarrier and keeps it phase-locked to the chroma burst of a composite video line. A 24-bit phase accumulator steps by a frequency word on every clock. Its top bits address a quarter-shifted pair of table lookups that give sine and cosine. Signed chroma samples are mixed with sine to form U and with cosine to form V. Each mixed stream then passes through a short moving-average filter that removes the double-frequency term.

While an external burst gate is high, the filtered V value is summed into a phase-error accumulator. On PAL-alternate lines its sign is flipped. At the end of the gate, a proportional-plus-integral correction with shift gains rewrites the frequency word. The integrator is clamped to a programmable bound. A line flag, qualified by a PAL mode input, rotates the cosine lookup by half a cycle.

Top module: `sc_burst_pll`

## Requirements
- R1: While `rst` is high at a rising edge, the phase, the integrator, the error sum, `sin_out`, `cos_out`, `u_out` and `v_out` become 0, and `freq_word` takes the value of `nominal_inc`.
- R2: Out of reset, the phase register grows by `freq_word` modulo 2^24 at every edge. At the next edge, `sin_out` takes table entry k, where k is phase[23:16], and entry k is round(511·sin(2πk/256)), rounded half away from zero.
- R3: With the effective PAL flag low, `cos_out` takes table entry (k+64) mod 256 at the same edge as `sin_out`.
- R4: The effective PAL flag is `pal_mode` AND `pal_line`. When it is high, the cosine index gains a further 128 (mod 256). `pal_line` has no effect while `pal_mode` is low.
- R5: At the edge where `sin_out`/`cos_out` are loaded, `chroma_in` is also captured. At the next edge the products floor(chroma·sin/512) and floor(chroma·cos/512) are registered. At the edge after that, `u_out`/`v_out` become floor(sum of the four newest products / 4).
- R6: At each edge where `burst_gate` is high, the error sum gains `v_out`, or loses `v_out` when the effective PAL flag is high. At any other edge it holds, except at the update of R7.
- R7: At the first edge with `burst_gate` low after an edge with it high, the integrator becomes I' = clamp(I + floor(E/256)), and `freq_word` becomes (`nominal_inc` + floor(E/16) + I') mod 2^24, where E is the error sum. The error sum is then cleared.
- R8: The clamp of R7 limits the integrator to the range −`int_limit` … +`int_limit`.
- R9: At every other edge out of reset, `freq_word` holds its value, even when `nominal_inc` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nominal_inc | input | 24 | Nominal phase increment per clock |
| int_limit | input | 23 | Integrator magnitude bound |
| chroma_in | input | 10 | Signed chroma sample |
| burst_gate | input | 1 | High during the burst window |
| pal_mode | input | 1 | Enables the per-line PAL flag |
| pal_line | input | 1 | High on PAL-alternate lines |
| sin_out | output | 10 | Signed sine of the local subcarrier |
| cos_out | output | 10 | Signed cosine, PAL-rotated when flagged |
| u_out | output | 10 | Filtered U (chroma mixed with sine) |
| v_out | output | 10 | Filtered V (chroma mixed with cosine) |
| freq_word | output | 24 | Current phase increment |

## Verification
`sin_out` and `cos_out` follow the phase register after one edge. The flag used for the rotation is the one present at that same edge. A chroma sample first appears in `u_out`/`v_out` two edges after the edge that captures it. `freq_word` changes only at the edge that first sees the gate low. That edge uses the error summed from `v_out` values of the preceding gated edges. The bench keeps a reference that advances by one edge for every clock, with the same inputs. It compares all five outputs at each falling edge, so every result is read in the cycle where it is due.

// File: rtl/sc_pll_pkg.sv
package sc_pll_pkg;
    localparam int SAMP_W = 10;

    typedef logic signed [SAMP_W-1:0] samp_t;

    typedef struct packed {
        samp_t s;
        samp_t c;
    } trig_t;

    typedef struct packed {
        samp_t u;
        samp_t v;
    } uv_t;

    // Rounded sine code, half away from zero; evaluated at elaboration only.
    function automatic int sine_code(int idx, int depth, int amp);
        real x;
        x = $itor(amp) * $sin(2.0 * 3.14159265358979 * $itor(idx) / $itor(depth));
        if (x >= 0.0)
            return $rtoi(x + 0.5);
        return -$rtoi(0.5 - x);
    endfunction
endpackage

// File: rtl/sc_trig_lut.sv
module sc_trig_lut
    import sc_pll_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] idx,
    input  logic          flip,
    output trig_t         trig
);
    localparam int DEPTH = 1 << AW;
    localparam int AMP   = (1 << (SAMP_W - 1)) - 1;
    localparam logic [AW-1:0] QTR  = AW'(DEPTH / 4);
    localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);

    samp_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        localparam int CODE = sine_code(i, DEPTH, AMP);
        assign rom[i] = samp_t'(CODE);
    end

    logic [AW-1:0] cidx;
    always_comb cidx = idx + QTR + (flip ? HALF : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= '0;
        end else begin
            trig.s <= rom[idx];
            trig.c <= rom[cidx];
        end
    end
endmodule

// File: rtl/sc_demod_lpf.sv
module sc_demod_lpf
    import sc_pll_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  samp_t chr,
    input  samp_t carrier,
    output samp_t filt
);
    localparam int PROD_W = 2 * SAMP_W;
    localparam int AVG_SH = $clog2(TAPS);
    localparam int SUM_W  = SAMP_W + AVG_SH;

    logic signed [PROD_W-1:0] prod;
    logic signed [SUM_W-1:0]  sum;
    samp_t                    mix_q;
    samp_t                    hist [TAPS-1];

    always_comb begin
        prod = chr * carrier;
        sum  = SUM_W'(mix_q);
        for (int k = 0; k < TAPS - 1; k++)
            sum += SUM_W'(hist[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_q <= '0;
            filt  <= '0;
            for (int k = 0; k < TAPS - 1; k++)
                hist[k] <= '0;
        end else begin
            mix_q   <= samp_t'(prod >>> (SAMP_W - 1));
            hist[0] <= mix_q;
            for (int k = 1; k < TAPS - 1; k++)
                hist[k] <= hist[k-1];
            filt <= samp_t'(sum >>> AVG_SH);
        end
    end
endmodule

// File: rtl/sc_loop_filter.sv
module sc_loop_filter
    import sc_pll_pkg::*;
#(
    parameter int PW = 24,
    parameter int EW = 20,
    parameter int KP = 4,
    parameter int KI = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          gate,
    input  logic          flip,
    input  samp_t         v_filt,
    input  logic [PW-1:0] nominal,
    input  logic [PW-2:0] limit,
    output logic [PW-1:0] inc
);
    logic                 gate_d;
    logic                 gate_end;
    logic signed [EW-1:0] err_acc;
    logic signed [PW-1:0] integ;
    logic signed [PW-1:0] pterm;
    logic signed [PW-1:0] iterm;
    logic signed [PW:0]   isum;
    logic signed [PW:0]   ilim;
    logic signed [PW:0]   inext;

    always_comb begin
        gate_end = gate_d & ~gate;
        pterm    = PW'(err_acc >>> KP);
        iterm    = PW'(err_acc >>> KI);
        isum     = (PW+1)'(integ) + (PW+1)'(iterm);
        ilim     = signed'({2'b00, limit});
        if (isum > ilim)
            inext = ilim;
        else if (isum < -ilim)
            inext = -ilim;
        else
            inext = isum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_d  <= 1'b0;
            err_acc <= '0;
            integ   <= '0;
            inc     <= nominal;
        end else begin
            gate_d <= gate;
            if (gate_end) begin
                integ   <= PW'(inext);
                inc     <= nominal + pterm + PW'(inext);
                err_acc <= '0;
            end else if (gate) begin
                err_acc <= flip ? err_acc - EW'(v_filt) : err_acc + EW'(v_filt);
            end
        end
    end
endmodule

// File: rtl/sc_burst_pll.sv
module sc_burst_pll
    import sc_pll_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int LUT_AW   = 8,
    parameter int ERR_W    = 20,
    parameter int KP_SH    = 4,
    parameter int KI_SH    = 8,
    parameter int AVG_TAPS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [PHASE_W-1:0]        nominal_inc,
    input  logic [PHASE_W-2:0]        int_limit,
    input  logic signed [SAMP_W-1:0]  chroma_in,
    input  logic                      burst_gate,
    input  logic                      pal_mode,
    input  logic                      pal_line,
    output logic signed [SAMP_W-1:0]  sin_out,
    output logic signed [SAMP_W-1:0]  cos_out,
    output logic signed [SAMP_W-1:0]  u_out,
    output logic signed [SAMP_W-1:0]  v_out,
    output logic [PHASE_W-1:0]        freq_word
);
    logic [PHASE_W-1:0] phase;
    logic [PHASE_W-1:0] inc;
    logic               flip;
    samp_t              chr_q;
    trig_t              trig;
    uv_t                uv;

    assign flip = pal_mode & pal_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            chr_q <= '0;
        end else begin
            phase <= phase + inc;
            chr_q <= chroma_in;
        end
    end

    sc_trig_lut #(.AW(LUT_AW)) u_lut (
        .clk  (clk),
        .rst  (rst),
        .idx  (phase[PHASE_W-1 -: LUT_AW]),
        .flip (flip),
        .trig (trig)
    );

    sc_demod_lpf #(.TAPS(AVG_TAPS)) u_dem_u (
        .clk     (clk),
        .rst     (rst),
        .chr     (chr_q),
        .carrier (trig.s),
        .filt    (uv.u)
    );

    sc_demod_lpf #(.TAPS(AVG_TAPS)) u_dem_v (
        .clk     (clk),
        .rst     (rst),
        .chr     (chr_q),
        .carrier (trig.c),
        .filt    (uv.v)
    );

    sc_loop_filter #(
        .PW (PHASE_W),
        .EW (ERR_W),
        .KP (KP_SH),
        .KI (KI_SH)
    ) u_loop (
        .clk     (clk),
        .rst     (rst),
        .gate    (burst_gate),
        .flip    (flip),
        .v_filt  (uv.v),
        .nominal (nominal_inc),
        .limit   (int_limit),
        .inc     (inc)
    );

    assign sin_out   = trig.s;
    assign cos_out   = trig.c;
    assign u_out     = uv.u;
    assign v_out     = uv.v;
    assign freq_word = inc;
endmodule

// File: rtl/sc_burst_pll_chk.sv
module sc_burst_pll_chk #(
    parameter int PW = 24,
    parameter int EW = 20,
    parameter int SW = 10
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 burst_gate,
    input logic [PW-1:0]        nominal_inc,
    input logic [PW-2:0]        int_limit,
    input logic [PW-1:0]        freq_word,
    input logic signed [SW-1:0] u_out,
    input logic signed [SW-1:0] v_out,
    input logic [PW-1:0]        phase,
    input logic signed [EW-1:0] err_acc,
    input logic signed [PW-1:0] integ
);
    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (freq_word == $past(nominal_inc)) && (u_out == '0) && (v_out == '0) && (phase == '0));

    // R2: phase steps by the frequency word
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase == PW'($past(phase) + $past(freq_word)));

    // R6: error sum moves only under the gate or is cleared
    a_r6_err_idle: assert property (@(posedge clk) disable iff (rst)
        !burst_gate |=> (err_acc == $past(err_acc)) || (err_acc == '0));

    // R8: integrator within bound after an update
    a_r8_int_bound: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(burst_gate, 2) && !$past(burst_gate))
        |-> ((PW+1)'(integ) <= signed'({2'b00, $past(int_limit)}))
         && ((PW+1)'(integ) >= -signed'({2'b00, $past(int_limit)})));

    // R9: frequency word holds outside the gate end
    a_r9_freq_hold: assert property (@(posedge clk) disable iff (rst)
        !($past(burst_gate) && !burst_gate) |=> $stable(freq_word));
endmodule

bind sc_burst_pll sc_burst_pll_chk #(
    .PW (PHASE_W),
    .EW (ERR_W),
    .SW (sc_pll_pkg::SAMP_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .burst_gate  (burst_gate),
    .nominal_inc (nominal_inc),
    .int_limit   (int_limit),
    .freq_word   (freq_word),
    .u_out       (u_out),
    .v_out       (v_out),
    .phase       (phase),
    .err_acc     (u_loop.err_acc),
    .integ       (u_loop.integ)
);

// File: tb/sc_burst_pll_tb.sv
module sc_burst_pll_tb;
    localparam int MASK = 32'h00FF_FFFF;
    localparam int KP = 4;
    localparam int KI = 8;
    localparam int LINE = 40;

    logic              clk = 1'b0;
    logic              rst;
    logic [23:0]       nominal_inc;
    logic [22:0]       int_limit;
    logic signed [9:0] chroma_in;
    logic              burst_gate, pal_mode, pal_line;
    logic signed [9:0] sin_out, cos_out, u_out, v_out;
    logic [23:0]       freq_word;

    always #10 clk = ~clk;

    sc_burst_pll u_dut (
        .clk(clk), .rst(rst), .nominal_inc(nominal_inc), .int_limit(int_limit),
        .chroma_in(chroma_in), .burst_gate(burst_gate), .pal_mode(pal_mode),
        .pal_line(pal_line), .sin_out(sin_out), .cos_out(cos_out),
        .u_out(u_out), .v_out(v_out), .freq_word(freq_word)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_ph, m_inc, m_s, m_c, m_chr, m_mu, m_mv, m_u, m_v, m_err, m_int;
    int m_hu [3];
    int m_hv [3];
    bit m_gd, m_flipgate, m_rst;
    string m_ctag, m_ftag;

    function automatic int tsin(int k);
        real x;
        x = 511.0 * $sin(2.0 * 3.14159265358979 * $itor(k) / 256.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(0.5 - x);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int k, n_s, n_c, n_mu, n_mv, n_u, n_v, n_err, n_int, n_inc, isum, lim;
        bit flip;
        m_rst = rst;
        if (rst) begin
            m_ph = 0; m_s = 0; m_c = 0; m_chr = 0; m_mu = 0; m_mv = 0;
            m_u = 0; m_v = 0; m_err = 0; m_int = 0; m_gd = 0; m_flipgate = 0;
            for (int i = 0; i < 3; i++) begin m_hu[i] = 0; m_hv[i] = 0; end
            m_inc = int'(nominal_inc);
            m_ctag = "R1"; m_ftag = "R1";
            return;
        end
        flip = pal_mode && pal_line;
        k = (m_ph >> 16) & 255;
        n_s = tsin(k);
        n_c = tsin((k + 64 + (flip ? 128 : 0)) & 255);
        m_ctag = pal_line ? "R4" : "R3";
        n_mu = (m_chr * m_s) >>> 9;
        n_mv = (m_chr * m_c) >>> 9;
        n_u = (m_mu + m_hu[0] + m_hu[1] + m_hu[2]) >>> 2;
        n_v = (m_mv + m_hv[0] + m_hv[1] + m_hv[2]) >>> 2;
        n_err = m_err; n_int = m_int; n_inc = m_inc;
        m_ftag = "R9";
        if (m_gd && !burst_gate) begin
            lim = int'(int_limit);
            isum = m_int + (m_err >>> KI);
            if (isum > lim) isum = lim;
            else if (isum < -lim) isum = -lim;
            m_ftag = (isum != m_int + (m_err >>> KI)) ? "R8" : (m_flipgate ? "R6" : "R7");
            n_int = isum;
            n_inc = (int'(nominal_inc) + (m_err >>> KP) + isum) & MASK;
            n_err = 0;
            m_flipgate = 0;
        end else if (burst_gate) begin
            n_err = flip ? m_err - m_v : m_err + m_v;
            if (flip) m_flipgate = 1;
        end
        m_hu[2] = m_hu[1]; m_hu[1] = m_hu[0]; m_hu[0] = m_mu;
        m_hv[2] = m_hv[1]; m_hv[1] = m_hv[0]; m_hv[0] = m_mv;
        m_ph = (m_ph + m_inc) & MASK;
        m_chr = int'(chroma_in);
        m_s = n_s; m_c = n_c; m_mu = n_mu; m_mv = n_mv; m_u = n_u; m_v = n_v;
        m_err = n_err; m_int = n_int; m_inc = n_inc; m_gd = burst_gate;
    endtask

    task automatic check_all();
        chk(m_rst ? "R1" : "R2", int'(sin_out), m_s);
        chk(m_ctag, int'(cos_out), m_c);
        chk(m_rst ? "R1" : "R5", int'(u_out), m_u);
        chk(m_rst ? "R1" : "R5", int'(v_out), m_v);
        chk(m_ftag, int'(freq_word), m_inc);
    endtask

    task automatic cycle(bit r, bit g, int c, bit pm, bit pl);
        rst = r; burst_gate = g; chroma_in = 10'(c); pal_mode = pm; pal_line = pl;
        model_step();
        @(negedge clk);
        check_all();
    endtask

    function automatic int burst_sample(int t, int amp);
        int n;
        n = int'($urandom_range(16)) - 8;
        return $rtoi(amp * $sin(2.0 * 3.14159265358979 * $itor(t) / 8.0 + 0.7)) + n;
    endfunction

    initial begin
        int t = 0;
        void'($urandom(32'd4242));
        nominal_inc = 24'h20_0000;
        int_limit = 23'h7F_FFFF;
        cycle(1, 0, 0, 0, 0);
        cycle(1, 1, 100, 1, 1);
        chk("R1", int'(freq_word), 32'h20_0000);
        chk("R1", int'(u_out), 0);
        for (int ln = 0; ln < 60; ln++) begin
            bit pm, pl;
            int seg = ln / 10;
            pm = (seg != 0);
            pl = ln[0];
            if (seg == 2) int_limit = 23'd3;
            else int_limit = 23'h7F_FFFF;
            for (int c = 0; c < LINE; c++) begin
                bit g;
                int smp;
                bit r;
                g = (c >= 4) && (c < 16 + (seg == 3 ? int'($urandom_range(8)) : 0));
                r = (ln == 25) && (c < 2);
                if (seg == 3) smp = int'($urandom_range(1023)) - 512;
                else if (seg == 4) smp = c[0] ? 511 : -512;
                else smp = burst_sample(t, 200 + 20 * seg);
                if (seg == 3 && c == 20) nominal_inc = 24'h1F_F000 + 24'($urandom_range(8192));
                if (seg == 5 && c == 30) nominal_inc = 24'h20_0400;
                cycle(r, g, smp, pm, pl);
                t++;
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule